// File: doc/BRIEF.md
# Incrementation-Based Carry-Skip Adder

This block adds two unsigned WIDTH-bit operands and a carry-in. The result is a WIDTH-bit sum and a carry-out, captured in one output register. The operands are cut into stages of STAGE bits, starting from the least significant end. When WIDTH is not a multiple of STAGE, the top stage is the short one.

The lowest stage is a plain ripple adder fed by the external carry-in. Every higher stage works in three steps:
- It adds its own slice with a ripple chain tied to a zero carry. This yields a provisional sum and a stage generate.
- A compound-gate skip cell combines the stage generate, the stage all-propagate flag and the carry from the stage below. The result is the carry that is passed upward.
- An incrementer folds the carry from below into the provisional sum.

The skip cells alternate between AND-OR-invert and OR-AND-invert forms. As a result, the carry wire between stages flips polarity at every stage. Each consumer of that wire reads it with the matching polarity. The carry-out of the incrementer itself is discarded.

Top module: `csk_adder`

## Requirements
- R1: One clock edge after the inputs are applied, {cout_o, sum_o} equals a_i + b_i + cin_i, computed as a WIDTH+1-bit unsigned value.
- R2: While rst_n is low, sum_o and cout_o are zero.
- R3: Each stage above stage 0 forms its provisional sum with a ripple chain whose carry-in is tied to 0. Its stage generate and its all-propagate flag (the AND of a^b over the slice) are never both 1.
- R4: For stage k, counted from 0 at the least significant end, the true carry out of the stage is generate OR (all-propagate AND the true carry out of stage k-1).
- R5: The inter-stage carry wire of stage k holds the inverted carry when k is odd and the true carry when k is even. Skip cells with a true input use the AND-OR-invert form. Skip cells with an inverted input use the OR-AND-invert form.
- R6: The incrementer of stage k passes the provisional sum unchanged when the true carry from stage k-1 is 0. When that carry is 1, it adds one modulo 2^width of the stage, so an all-ones provisional sum wraps to zero.
- R7: Stage 0 uses cin_i directly as its ripple carry-in and has no incrementer.
- R8: When WIDTH is not a multiple of STAGE, the top stage holds the remaining WIDTH mod STAGE bits, and R1 still holds.
- R9: cout_o is the carry of the top stage, restored to true polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |

## Verification
The assertions check every cycle that the registered result matches the arithmetic sum of the previous cycle's inputs. They also check, per stage, that:
- generate and all-propagate are exclusive;
- a propagating stage forwards its incoming true carry unchanged;
- a generating stage forwards a true 1;
- the incrementer is transparent when its carry is 0.

Only the bench scenarios show three further behaviours:
- the reset value;
- the wrap of an all-ones provisional sum, seen when a long carry is forced through several fully propagating stages with cin_i at both values;
- the short top stage, covered by an exhaustive sweep at a six-bit width.

// File: rtl/csk_pkg.sv
package csk_pkg;

    // Inter-stage carry wires alternate polarity: odd stages carry the complement.
    function automatic logic carry_true(input logic raw, input int unsigned stage);
        return (stage % 2 == 1) ? ~raw : raw;
    endfunction

    function automatic int unsigned stage_count(input int unsigned width, input int unsigned stage);
        return (width + stage - 1) / stage;
    endfunction

endpackage

// File: rtl/csk_ripple.sv
module csk_ripple #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         pall_o
);
    logic [W:0]   chain;
    logic [W-1:0] half;

    assign chain[0] = cin_i;
    assign half     = a_i ^ b_i;

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign sum_o[k]     = half[k] ^ chain[k];
        assign chain[k + 1] = (a_i[k] & b_i[k]) | (half[k] & chain[k]);
    end

    assign cout_o = chain[W];
    assign pall_o = &half;
endmodule

// File: rtl/csk_skip_cell.sv
module csk_skip_cell #(
    parameter bit IN_INV = 1'b0
) (
    input  logic gen_i,
    input  logic pall_i,
    input  logic carry_i,
    output logic carry_o
);
    if (!IN_INV) begin : g_aoi
        // True carry in, complemented carry out.
        assign carry_o = ~(gen_i | (pall_i & carry_i));
    end else begin : g_oai
        // Complemented carry in, true carry out.
        assign carry_o = ~((~gen_i) & ((~pall_i) | carry_i));
    end
endmodule

// File: rtl/csk_incr.sv
module csk_incr #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] isum_i,
    input  logic         carry_i,
    output logic [W-1:0] sum_o
);
    logic [W:0] prefix;

    assign prefix[0] = 1'b1;
    for (genvar k = 0; k < W; k++) begin : g_bit
        assign prefix[k + 1] = prefix[k] & isum_i[k];
        assign sum_o[k]      = isum_i[k] ^ (carry_i & prefix[k]);
    end
endmodule

// File: rtl/csk_adder.sv
module csk_adder
    import csk_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned STAGE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int unsigned NSTG = stage_count(WIDTH, STAGE);

    typedef struct packed {
        logic             cout;
        logic [WIDTH-1:0] sum;
    } result_t;

    result_t          res_d, res_q;
    logic [WIDTH-1:0] sum_w;
    logic             carry_w [NSTG];
    logic             ctrue_w [NSTG];
    logic             gen_w   [NSTG];
    logic             pall_w  [NSTG];

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        localparam int unsigned LO = s * STAGE;
        localparam int unsigned SW = (s == NSTG - 1) ? (WIDTH - LO) : STAGE;
        localparam int unsigned HI = LO + SW - 1;

        assign ctrue_w[s] = carry_true(carry_w[s], s);

        if (s == 0) begin : g_first
            // R7: plain ripple stage fed by the external carry
            csk_ripple #(.W(SW)) u_rca (
                .a_i   (a_i[HI:LO]),
                .b_i   (b_i[HI:LO]),
                .cin_i (cin_i),
                .sum_o (sum_w[HI:LO]),
                .cout_o(carry_w[s]),
                .pall_o(pall_w[s])
            );
            assign gen_w[s] = carry_w[s];
        end else begin : g_upper
            logic [SW-1:0] isum;

            csk_ripple #(.W(SW)) u_rca (
                .a_i   (a_i[HI:LO]),
                .b_i   (b_i[HI:LO]),
                .cin_i (1'b0),
                .sum_o (isum),
                .cout_o(gen_w[s]),
                .pall_o(pall_w[s])
            );

            csk_skip_cell #(.IN_INV((s - 1) % 2 == 1)) u_skip (
                .gen_i  (gen_w[s]),
                .pall_i (pall_w[s]),
                .carry_i(carry_w[s - 1]),
                .carry_o(carry_w[s])
            );

            csk_incr #(.W(SW)) u_inc (
                .isum_i (isum),
                .carry_i(ctrue_w[s - 1]),
                .sum_o  (sum_w[HI:LO])
            );

            assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !(gen_w[s] && pall_w[s]));
            assert_skip_prop_R4: assert property (@(posedge clk) disable iff (!rst_n)
                pall_w[s] |-> (ctrue_w[s] == ctrue_w[s - 1]));
            assert_skip_gen_R5: assert property (@(posedge clk) disable iff (!rst_n)
                gen_w[s] |-> ctrue_w[s]);
            assert_incr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !ctrue_w[s - 1] |-> (sum_w[HI:LO] == isum));
        end
    end

    always_comb begin
        res_d      = res_q;
        res_d.sum  = sum_w;
        res_d.cout = ctrue_w[NSTG - 1];   // R9
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign sum_o  = res_q.sum;
    assign cout_o = res_q.cout;

    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({cout_o, sum_o} ==
            ((WIDTH + 1)'($past(a_i)) + (WIDTH + 1)'($past(b_i)) + (WIDTH + 1)'($past(cin_i)))));
endmodule

// File: tb/csk_adder_tb.sv
module csk_adder_tb;
    localparam int unsigned W  = 16;
    localparam int unsigned WS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a = '0, b = '0;
    logic          cin = 1'b0;
    logic [W-1:0]  sum;
    logic          cout;
    logic [WS-1:0] as = '0, bs = '0;
    logic          cins = 1'b0;
    logic [WS-1:0] sums;
    logic          couts;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    csk_adder #(.WIDTH(W), .STAGE(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout)
    );

    csk_adder #(.WIDTH(WS), .STAGE(4)) u_small (
        .clk(clk), .rst_n(rst_n), .a_i(as), .b_i(bs), .cin_i(cins),
        .sum_o(sums), .cout_o(couts)
    );

    task automatic check(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, then sample at the next falling edge (one register).
    task automatic apply16(input string tag, input logic [W-1:0] x, input logic [W-1:0] y,
                           input logic c);
        longint exp;
        a = x; b = y; cin = c;
        exp = longint'(x) + longint'(y) + longint'(c);
        @(negedge clk);
        check(tag, {cout, sum}, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        a = 16'h1234; b = 16'h4321; cin = 1'b1;
        @(negedge clk);
        check("R2 reset sum", sum, 0);
        check("R2 reset cout", cout, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R6: all-propagate through every stage, both carry-in values
        apply16("R4 all-propagate cin0", 16'h5555, 16'hAAAA, 1'b0);
        apply16("R4 R6 all-propagate cin1 wraps", 16'h5555, 16'hAAAA, 1'b1);
        apply16("R9 all-ones plus one", 16'hFFFF, 16'h0000, 1'b1);
        apply16("R9 max operands", 16'hFFFF, 16'hFFFF, 1'b1);
        apply16("R6 wrap in middle stages", 16'h0FFF, 16'h0001, 1'b0);
        apply16("R7 carry-in only", 16'h0000, 16'h0000, 1'b1);
        apply16("R5 generate in odd stage", 16'h00F0, 16'h0010, 1'b0);
        apply16("R5 generate in even stage", 16'h0F00, 16'h0100, 1'b0);
        apply16("R3 stage generate blocked from skip", 16'h0880, 16'h0880, 1'b1);
        apply16("R1 zero", 16'h0000, 16'h0000, 1'b0);

        for (int i = 0; i < 2000; i++)
            apply16("R1 random", W'($urandom), W'($urandom), 1'($urandom));

        // R8: short top stage, exhaustive
        for (int v = 0; v < (1 << (2 * WS + 1)); v++) begin
            longint exp;
            as   = WS'(v);
            bs   = WS'(v >> WS);
            cins = v[2*WS];
            exp  = longint'(as) + longint'(bs) + longint'(cins);
            @(negedge clk);
            check("R8 short stage exhaustive", {couts, sums}, exp);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule